// File: doc/BRIEF.md
# Vector NaN Propagation Fixup Stage

This stage sits directly behind a 128-bit SIMD floating-point adder. It receives the two source vectors, the adder's raw result vector, an element-size select and a half-width select. For each active lane it checks whether either source element is a NaN. When one is, the raw result for that lane is discarded. The lane then carries one of the source NaNs, picked by a fixed priority and always made quiet. Lanes without a NaN source keep the adder's result bit for bit.

The result vector and one NaN-hit flag per lane are registered together. They appear one cycle after an accepted input, marked by `out_valid`. In half-width mode only the lower half of the vector is active, and the upper half of the output is forced to zero. Invalid-operation NaN generation, exception flags, rounding and min/max special rules belong to other parts of the datapath.

Top module: `nanfix_stage`

## Requirements
- R1: An element is a NaN when its value with the sign bit cleared is strictly greater than the infinity pattern: 0x7F800000 for 32-bit elements and 0x7FF0000000000000 for 64-bit elements. Infinities of either sign are not NaN. A 32-bit decision uses only the bits of its own 32-bit slice.
- R2: When exactly one source element of a lane is a NaN, the output is that element with its quiet bit set to 1. The quiet bit is bit 22 of a 32-bit element and bit 51 of a 64-bit element. The sign and all other payload bits are unchanged.
- R3: When both source elements are NaN and `src_a` is signaling (quiet bit 0), the output is `src_a` with the quiet bit set.
- R4: When both are NaN, `src_a` is quiet and `src_b` is signaling, the output is `src_b` with the quiet bit set.
- R5: When both are NaN and both are quiet, the output is `src_a` unchanged.
- R6: An active lane where neither source is NaN outputs the raw result of that lane unmodified.
- R7: With `in_half`=1 only the lower half of the lanes is active: lanes 0..1 of 32 bits, or lane 0 of 64 bits. The upper 64 output bits are zero, the upper lanes' hit flags are 0, and NaNs in the upper operand bits have no effect.
- R8: `in_wide`=0 selects four 32-bit lanes, where lane i occupies bits 32i+31..32i. `in_wide`=1 selects two 64-bit lanes, where lane j occupies bits 64j+63..64j. `out_hit[i]` is set when lane i is active and has a NaN source. In 64-bit mode `out_hit[3:2]` is 0.
- R9: An input accepted with `in_valid`=1 produces its `out_res`/`out_hit` on the next clock edge, with `out_valid`=1 in that cycle. When `in_valid`=0, `out_valid` falls and `out_res`/`out_hit` hold their previous values.
- R10: A synchronous reset with `rst_n`=0 clears `out_valid`, `out_res` and `out_hit` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input vectors are valid this cycle |
| in_wide | input | 1 | 0: four 32-bit lanes, 1: two 64-bit lanes |
| in_half | input | 1 | 1: only the lower half of the lanes is active |
| src_a | input | 128 | First source operand vector |
| src_b | input | 128 | Second source operand vector |
| raw_res | input | 128 | Raw arithmetic result vector from the adder |
| out_valid | output | 1 | Registered result is valid |
| out_res | output | 128 | Result vector after NaN fixup |
| out_hit | output | 4 | Per-lane NaN-detected flags |

## Verification
On every cycle the assertions check three things. First, the valid timing and the hold of the result while idle. Second, that a flagged lane always leaves with its quiet bit set. Third, that the upper half is zero and its flags are low in half-width mode, and that the upper flags stay low in 64-bit mode. The choice of which operand wins is visible only in the bench scenarios, because it depends on the operand values. Those scenarios include signaling versus quiet in either operand, negative NaNs and infinities. The same is true of exact payload preservation, of passing the raw result through unchanged, and of keeping the 32-bit lanes independent when a pattern would read as a NaN in 64-bit mode.

// File: rtl/nanfix_pkg.sv
// Package: shared lane geometry and element-size encoding for the NaN fixup stage.
// Assumes IEEE-754 binary32/binary64 layouts (sign, exponent, fraction).
package nanfix_pkg;
    localparam int SGL_W      = 32;
    localparam int SGL_FRAC_W = 23;
    localparam int DBL_W      = 64;
    localparam int DBL_FRAC_W = 52;

    typedef enum logic {
        ELEM_32 = 1'b0,
        ELEM_64 = 1'b1
    } elem_e;
endpackage

// File: rtl/nanfix_lane.sv
// Module: one lane of NaN propagation for a parameterised float format.
// Detects NaN in either source, picks the propagated operand by priority
// (single NaN, signaling A, signaling B, A) and forces its quiet bit.
// Assumes LANE_W = 1 + exponent + FRAC_W. An inactive lane outputs zero.
module nanfix_lane #(
    parameter int LANE_W = 32,
    parameter int FRAC_W = 23
) (
    input  logic              en,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  logic [LANE_W-1:0] raw,
    output logic [LANE_W-1:0] res,
    output logic              hit
);
    localparam int EXP_W = LANE_W - 1 - FRAC_W;
    localparam int QBIT  = FRAC_W - 1;
    localparam logic [LANE_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [LANE_W-1:0] QMASK   = {{(LANE_W-1-QBIT){1'b0}}, 1'b1, {QBIT{1'b0}}};

    logic              a_nan;
    logic              b_nan;
    logic [LANE_W-1:0] pick;

    // Classify each operand by comparing its magnitude with infinity.
    always_comb begin
        a_nan = a[LANE_W-2:0] > INF_MAG;
        b_nan = b[LANE_W-2:0] > INF_MAG;
    end

    // Select the NaN operand to propagate by priority.
    always_comb begin
        if (a_nan && !b_nan)      pick = a;
        else if (!a_nan && b_nan) pick = b;
        else if (!a[QBIT])        pick = a;
        else if (!b[QBIT])        pick = b;
        else                      pick = a;
    end

    // Drive the lane output: zero when inactive, quieted NaN on hit, else raw.
    always_comb begin
        hit = en && (a_nan || b_nan);
        if (!en)      res = '0;
        else if (hit) res = pick | QMASK;
        else          res = raw;
    end
endmodule

// File: rtl/nanfix_core.sv
// Module: combinational vector fixup. Builds both 32-bit and 64-bit lane
// arrays and selects one by element size. Half mode deactivates the upper
// half of the lanes. Assumes VEC_W is a multiple of 64.
module nanfix_core
    import nanfix_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  elem_e                   size,
    input  logic                    half,
    input  logic [VEC_W-1:0]        a,
    input  logic [VEC_W-1:0]        b,
    input  logic [VEC_W-1:0]        raw,
    output logic [VEC_W-1:0]        res,
    output logic [VEC_W/SGL_W-1:0]  hit
);
    localparam int N_SGL = VEC_W / SGL_W;
    localparam int N_DBL = VEC_W / DBL_W;

    logic [VEC_W-1:0] res_sgl;
    logic [VEC_W-1:0] res_dbl;
    logic [N_SGL-1:0] hit_sgl;
    logic [N_DBL-1:0] hit_dbl;

    for (genvar i = 0; i < N_SGL; i++) begin : g_sgl
        logic en_i;
        // Lane is active unless half mode excludes the upper lanes.
        always_comb en_i = !half || (i < N_SGL / 2);
        nanfix_lane #(.LANE_W(SGL_W), .FRAC_W(SGL_FRAC_W)) u_lane (
            .en  (en_i),
            .a   (a[i*SGL_W +: SGL_W]),
            .b   (b[i*SGL_W +: SGL_W]),
            .raw (raw[i*SGL_W +: SGL_W]),
            .res (res_sgl[i*SGL_W +: SGL_W]),
            .hit (hit_sgl[i])
        );
    end

    for (genvar j = 0; j < N_DBL; j++) begin : g_dbl
        logic en_j;
        // Lane is active unless half mode excludes the upper lanes.
        always_comb en_j = !half || (j < N_DBL / 2);
        nanfix_lane #(.LANE_W(DBL_W), .FRAC_W(DBL_FRAC_W)) u_lane (
            .en  (en_j),
            .a   (a[j*DBL_W +: DBL_W]),
            .b   (b[j*DBL_W +: DBL_W]),
            .raw (raw[j*DBL_W +: DBL_W]),
            .res (res_dbl[j*DBL_W +: DBL_W]),
            .hit (hit_dbl[j])
        );
    end

    // Choose the lane array that matches the element size.
    always_comb begin
        if (size == ELEM_64) begin
            res = res_dbl;
            hit = {{(N_SGL-N_DBL){1'b0}}, hit_dbl};
        end else begin
            res = res_sgl;
            hit = hit_sgl;
        end
    end
endmodule

// File: rtl/nanfix_stage.sv
// Module: top of the NaN fixup stage. Registers the fixed-up vector and the
// per-lane hit flags with one cycle of latency and a valid bit.
// Assumes the adder presents operands and raw result in the same cycle.
module nanfix_stage
    import nanfix_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_wide,
    input  logic                    in_half,
    input  logic [VEC_W-1:0]        src_a,
    input  logic [VEC_W-1:0]        src_b,
    input  logic [VEC_W-1:0]        raw_res,
    output logic                    out_valid,
    output logic [VEC_W-1:0]        out_res,
    output logic [VEC_W/32-1:0]     out_hit
);
    localparam int N_SGL = VEC_W / SGL_W;
    localparam int N_DBL = VEC_W / DBL_W;
    localparam int HALF  = VEC_W / 2;

    elem_e            size;
    logic [VEC_W-1:0] fix_res;
    logic [N_SGL-1:0] fix_hit;

    // Map the size select onto the element encoding.
    always_comb size = elem_e'(in_wide);

    nanfix_core #(.VEC_W(VEC_W)) u_core (
        .size (size),
        .half (in_half),
        .a    (src_a),
        .b    (src_b),
        .raw  (raw_res),
        .res  (fix_res),
        .hit  (fix_hit)
    );

    // Output register: load on valid input, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_res   <= '0;
            out_hit   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_res <= fix_res;
                out_hit <= fix_hit;
            end
        end
    end

    a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r9_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_res) && $stable(out_hit)));
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_half) |=> (out_res[VEC_W-1:HALF] == '0 && out_hit[N_SGL-1:N_SGL/2] == '0));
    a_r8_wide_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_wide) |=> (out_hit[N_SGL-1:N_DBL] == '0));

    for (genvar i = 0; i < N_SGL; i++) begin : g_chk_sgl
        a_r2_quiet_sgl: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_wide) |=> (!out_hit[i] || out_res[i*SGL_W + SGL_FRAC_W - 1]));
    end
    for (genvar j = 0; j < N_DBL; j++) begin : g_chk_dbl
        a_r2_quiet_dbl: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_wide) |=> (!out_hit[j] || out_res[j*DBL_W + DBL_FRAC_W - 1]));
    end
endmodule

// File: tb/nanfix_stage_tb.sv
`timescale 1ns/1ps
module nanfix_stage_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_wide = 1'b0;
    logic         in_half = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] raw_res = '0;
    logic         out_valid;
    logic [127:0] out_res;
    logic [3:0]   out_hit;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [127:0] res;
        logic [3:0]   hit;
        string        tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    nanfix_stage u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wide(in_wide),
        .in_half(in_half), .src_a(src_a), .src_b(src_b), .raw_res(raw_res),
        .out_valid(out_valid), .out_res(out_res), .out_hit(out_hit)
    );

    function automatic logic [31:0] m32(input logic [31:0] a, b, r, output logic h);
        logic na, nb;
        logic [31:0] y;
        na = {1'b0, a[30:0]} > 32'h7F800000;
        nb = {1'b0, b[30:0]} > 32'h7F800000;
        h  = na | nb;
        if (na && nb) y = !a[22] ? a : (!b[22] ? b : a);
        else if (na)  y = a;
        else if (nb)  y = b;
        else          y = r;
        if (h) y[22] = 1'b1;
        return y;
    endfunction

    function automatic logic [63:0] m64(input logic [63:0] a, b, r, output logic h);
        logic na, nb;
        logic [63:0] y;
        na = {1'b0, a[62:0]} > 64'h7FF0000000000000;
        nb = {1'b0, b[62:0]} > 64'h7FF0000000000000;
        h  = na | nb;
        if (na && nb) y = !a[51] ? a : (!b[51] ? b : a);
        else if (na)  y = a;
        else if (nb)  y = b;
        else          y = r;
        if (h) y[51] = 1'b1;
        return y;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act, exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: compute expected item, push to scoreboard, present one vector.
    task automatic send(input bit wide, half, input logic [127:0] a, b, r, input string tag);
        exp_t e;
        logic h;
        e.res = '0;
        e.hit = '0;
        e.tag = tag;
        if (!wide) begin
            for (int i = 0; i < 4; i++) begin
                if (!half || i < 2) begin
                    e.res[i*32 +: 32] = m32(a[i*32 +: 32], b[i*32 +: 32], r[i*32 +: 32], h);
                    e.hit[i] = h;
                end
            end
        end else begin
            for (int j = 0; j < 2; j++) begin
                if (!half || j < 1) begin
                    e.res[j*64 +: 64] = m64(a[j*64 +: 64], b[j*64 +: 64], r[j*64 +: 64], h);
                    e.hit[j] = h;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b1; in_wide = wide; in_half = half;
        src_a = a; src_b = b; raw_res = r;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pop and compare each result as it appears.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9 unexpected out_valid", out_res, '0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_res == e.res && out_hit == e.hit, e.tag,
                      {out_hit, out_res[123:0]}, {e.hit, e.res[123:0]});
                if (out_res != e.res)
                    $display("      full res %h exp %h, hit %b exp %b", out_res, e.res, out_hit, e.hit);
            end
        end
    end

    function automatic logic [31:0] pick32();
        logic s;
        s = 1'($urandom);
        case ($urandom % 6)
            0: return 32'($urandom);
            1: return {s, 8'hFF, 23'h0};
            2: return {s, 8'hFF, 1'b1, 22'($urandom)};
            3: return {s, 8'hFF, 1'b0, 22'($urandom) | 22'h1};
            4: return 32'h0;
            default: return {s, 8'h7F, 23'($urandom)};
        endcase
    endfunction

    function automatic logic [63:0] pick64();
        logic s;
        s = 1'($urandom);
        case ($urandom % 6)
            0: return {32'($urandom), 32'($urandom)};
            1: return {s, 11'h7FF, 52'h0};
            2: return {s, 11'h7FF, 1'b1, 19'($urandom), 32'($urandom)};
            3: return {s, 11'h7FF, 1'b0, 19'($urandom), 32'($urandom) | 32'h1};
            4: return 64'h0;
            default: return {s, 11'h3FF, 20'($urandom), 32'($urandom)};
        endcase
    endfunction

    initial begin
        logic [127:0] held_res;
        logic [3:0]   held_hit;
        logic [127:0] ra, rb, rr;

        repeat (3) @(negedge clk);
        // R10: reset state
        check(out_valid == 1'b0, "R10 reset out_valid", {127'h0, out_valid}, '0);
        check(out_res == '0 && out_hit == '0, "R10 reset out_res/out_hit", out_res, '0);
        rst_n = 1'b1;

        // R6: no NaN anywhere, raw passes through (32-bit)
        send(0, 0, {32'h3F800000, 32'h40000000, 32'hC0400000, 32'h00000001},
                   {32'h3F800000, 32'h00000000, 32'h80000000, 32'h7F7FFFFF},
                   128'h11112222_33334444_55556666_77778888, "R6 pass 32");
        // R1: infinities of both signs are not NaN
        send(0, 0, {32'h7F800000, 32'hFF800000, 32'h7F800000, 32'h7F800001},
                   {32'hFF800000, 32'h7F800000, 32'h00000000, 32'h00000000},
                   128'hAAAA0000_BBBB0000_CCCC0000_DDDD0000, "R1 inf vs nan 32");
        // R2: single signaling NaN in A (negative), single in B
        send(0, 0, {32'hFF800123, 32'h3F800000, 32'h7FC00055, 32'h00000000},
                   {32'h3F800000, 32'hFF812345, 32'h00000000, 32'h7F800001},
                   128'h0, "R2 single nan 32");
        // R3/R4/R5: both NaN orderings (32-bit)
        send(0, 0, {32'h7F800011, 32'hFFC00022, 32'h7FC00033, 32'hFF800044},
                   {32'h7FC00099, 32'h7F800088, 32'hFFC00077, 32'h7F800066},
                   128'h0, "R3 R4 R5 both nan 32");
        // R2/R3/R4/R5 for 64-bit lanes
        send(1, 0, {64'hFFF0000000000ABC, 64'h3FF0000000000000},
                   {64'h3FF0000000000000, 64'h7FF0000000001234},
                   128'h1, "R2 single nan 64");
        send(1, 0, {64'h7FF0000000000011, 64'h7FF8000000000022},
                   {64'hFFF8000000000033, 64'hFFF0000000000044},
                   128'h0, "R3 R4 both nan 64");
        send(1, 0, {64'hFFF8000000000055, 64'h7FF0000000000000},
                   {64'h7FF8000000000066, 64'hFFF0000000000000},
                   128'h12345678_9ABCDEF0_0FEDCBA9_87654321, "R5 R1 quiet pair and inf 64");
        // R8: 32-bit NaN patterns that are not NaN as 64-bit elements
        send(1, 0, {32'h00000000, 32'h7F800001, 32'h7F800001, 32'h00000000},
                   128'h0, 128'hCAFEF00D_0BADBEEF_DEADC0DE_FEEDFACE, "R8 wide ignores 32-bit patterns");
        send(0, 0, {32'h3FF00000, 32'h00000001, 32'h7FF00000, 32'h00000001},
                   128'h0, 128'h5, "R8 R1 narrow slices independent");
        // R7: half width, upper lanes hold NaNs and must be ignored
        send(0, 1, {32'h7F800001, 32'hFF800002, 32'h7F800003, 32'h3F800000},
                   {32'h7F800004, 32'h00000000, 32'h00000000, 32'h40000000},
                   {32'h1, 32'h2, 32'h3, 32'h4}, "R7 half 32");
        send(1, 1, {64'h7FF0000000000001, 64'hFFF0000000000009},
                   {64'h7FF0000000000002, 64'h0},
                   {64'hFFFF, 64'hEEEE}, "R7 half 64");
        send(1, 1, {64'h7FF0000000000001, 64'h3FF0000000000000},
                   {64'h0, 64'h4000000000000000},
                   {64'hFFFF, 64'hEEEE}, "R7 R6 half 64 clean");
        idle(2);

        // R9: hold while idle
        held_res = out_res;
        held_hit = out_hit;
        @(negedge clk);
        src_a = {4{32'h7F800001}}; src_b = '0; raw_res = '1;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9 out_valid low when idle", {127'h0, out_valid}, '0);
        check(out_res == held_res && out_hit == held_hit, "R9 hold while idle", out_res, held_res);

        // Back-to-back random mixes of all modes
        for (int n = 0; n < 300; n++) begin
            bit w, hf;
            w  = 1'($urandom);
            hf = ($urandom % 4) == 0;
            rr = {32'($urandom), 32'($urandom), 32'($urandom), 32'($urandom)};
            if (w) begin
                ra = {pick64(), pick64()};
                rb = {pick64(), pick64()};
            end else begin
                ra = {pick32(), pick32(), pick32(), pick32()};
                rb = {pick32(), pick32(), pick32(), pick32()};
            end
            send(w, hf, ra, rb, rr, "R1 R2 R3 R4 R5 R6 R7 R8 random mix");
            if ((n % 17) == 0) idle(1);
        end
        idle(3);
        check(sb.size() == 0, "R9 every input produced one output", 128'(sb.size()), '0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R9: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule